// File: doc/BRIEF.md
# Sixteen-Bit Lookahead-Expanded ALU

This block is a purely combinational 16-bit arithmetic logic unit. A 3-bit select code picks one of eight operations, and every slice of the word uses that same code. There are three arithmetic operations: A+B, A−B and B−A. There are three bitwise operations: AND, OR and XOR. The last two codes force the result to all zeros or all ones.

The word is built from four 4-bit slices. Each of the three lower slices reports an active-low group generate and an active-low group propagate. A lookahead carry unit uses these signals, together with the global carry input, to compute the carry into slices 1, 2 and 3 in one step, with no ripple between slices. Inside a slice, the carry ripples from bit to bit. The most significant slice does not report group signals. Instead it provides the final carry-out and a two's-complement overflow flag.

For the two subtraction codes, the caller drives the carry input to 1. With a carry input of 0, the result is one less than the true difference. The carry-out and overflow flags mean something only in the three arithmetic codes. In all other codes they are held at 0.

Top module: `alu16_la`

## Requirements
- R1: With sel = 3 (add), {cout, f} equals a + b + cin taken as a 17-bit sum.
- R2: With sel = 2 (A minus B), {cout, f} equals a + ~b + cin as a 17-bit sum. With cin = 1 this gives f = a − b mod 2^16 and cout = 1 exactly when a ≥ b unsigned.
- R3: With sel = 1 (B minus A), {cout, f} equals b + ~a + cin as a 17-bit sum. With cin = 1 this gives f = b − a mod 2^16.
- R4: With sel = 4, 5 and 6, f equals a XOR b, a OR b and a AND b respectively. cin has no effect on f.
- R5: With sel = 0, f is 0x0000. With sel = 7, f is 0xFFFF. In both codes the result does not depend on a, b or cin.
- R6: For sel = 0, 4, 5, 6 and 7, both cout and ovf are 0.
- R7: In the three arithmetic codes, ovf is 1 exactly when the two effective addends share bit 15 and the result's bit 15 differs from it. The effective addends are a and b for add, a and ~b for A minus B, and ~a and b for B minus A.
- R8: A carry generated in any slice reaches every higher slice. Examples: 0x000F+1 = 0x0010, 0x00FF+1 = 0x0100, 0x0FFF+1 = 0x1000, and 0xFFFF+0 with cin = 1 gives 0x0000 with cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| sel | input | 3 | Operation select code (0 clear, 1 B−A, 2 A−B, 3 add, 4 XOR, 5 OR, 6 AND, 7 all ones) |
| cin | input | 1 | Carry into the least significant bit |
| f_out | output | 16 | Result word |
| cout | output | 1 | Carry out of bit 15 (arithmetic codes only) |
| ovf | output | 1 | Two's-complement overflow (arithmetic codes only) |

## Verification
The assertions are immediate checks that run whenever the inputs change. They assume every input is a settled two-state value, so they never see a half-updated operand or an unknown select code. The bench meets this assumption. It changes all inputs together just after a rising clock edge and compares the outputs at the falling edge. By then the combinational paths have had half a period to settle.

// File: rtl/alu16_la.sv
module alu16_la (
  input  logic [15:0] a_in,
  input  logic [15:0] b_in,
  input  logic [2:0]  sel,
  input  logic        cin,
  output logic [15:0] f_out,
  output logic        cout,
  output logic        ovf
);
  localparam int SW = 4;
  localparam int NS = 4;
  localparam int W  = SW * NS;

  localparam logic [2:0] OP_CLR = 3'd0;
  localparam logic [2:0] OP_BSA = 3'd1;
  localparam logic [2:0] OP_ASB = 3'd2;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_OR  = 3'd5;
  localparam logic [2:0] OP_AND = 3'd6;
  localparam logic [2:0] OP_SET = 3'd7;

  logic          arith;
  logic [W-1:0]  x, y, g, p, f_ar;
  logic [NS-1:0] cs;
  logic [NS-2:0] gn, pn;
  logic          c_msb_in, c_msb_out;

  assign arith = ~sel[2] & (sel[1] | sel[0]);
  assign x = (sel == OP_BSA) ? ~a_in : a_in;
  assign y = (sel == OP_ASB) ? ~b_in : b_in;
  assign g = x & y;
  assign p = x | y;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    logic [SW-1:0] sum;
    logic          c_last_in, c_last_out;
    always_comb begin
      logic c;
      c = cs[s];
      c_last_in = c;
      for (int j = 0; j < SW; j++) begin
        sum[j] = x[s*SW+j] ^ y[s*SW+j] ^ c;
        c_last_in = c;
        c = g[s*SW+j] | (p[s*SW+j] & c);
      end
      c_last_out = c;
    end
    assign f_ar[s*SW +: SW] = sum;

    if (s < NS-1) begin : g_gp
      logic gg, pp;
      always_comb begin
        gg = 1'b0;
        pp = 1'b1;
        for (int j = 0; j < SW; j++) begin
          gg = g[s*SW+j] | (p[s*SW+j] & gg);
          pp = pp & p[s*SW+j];
        end
      end
      assign gn[s] = ~gg;
      assign pn[s] = ~pp;
    end else begin : g_top
      assign c_msb_in  = c_last_in;
      assign c_msb_out = c_last_out;
    end
  end

  always_comb begin
    logic [NS-2:0] gh, ph;
    logic          term, acc;
    gh = ~gn;
    ph = ~pn;
    cs[0] = cin;
    for (int k = 0; k < NS-1; k++) begin
      term = cin;
      for (int m = 0; m <= k; m++) term = term & ph[m];
      acc = term;
      for (int m = 0; m <= k; m++) begin
        term = gh[m];
        for (int q = m + 1; q <= k; q++) term = term & ph[q];
        acc = acc | term;
      end
      cs[k+1] = acc;
    end
  end

  always_comb begin
    case (sel)
      OP_CLR:  f_out = '0;
      OP_XOR:  f_out = a_in ^ b_in;
      OP_OR:   f_out = a_in | b_in;
      OP_AND:  f_out = a_in & b_in;
      OP_SET:  f_out = '1;
      default: f_out = f_ar;
    endcase
  end

  assign cout = arith & c_msb_out;
  assign ovf  = arith & (c_msb_in ^ c_msb_out);
endmodule

// File: rtl/alu16_la_chk.sv
module alu16_la_chk (
  input logic [15:0] a_in,
  input logic [15:0] b_in,
  input logic [2:0]  sel,
  input logic        cin,
  input logic [15:0] f_out,
  input logic        cout,
  input logic        ovf
);
  logic [15:0] ea, eb;
  logic [16:0] ref_sum;
  assign ea = (sel == 3'd1) ? ~a_in : a_in;
  assign eb = (sel == 3'd2) ? ~b_in : b_in;
  assign ref_sum = {1'b0, ea} + {1'b0, eb} + {16'd0, cin};

  always_comb begin
    // R5
    clear_chk: assert (sel != 3'd0 || f_out == 16'h0000);
    // R5
    preset_chk: assert (sel != 3'd7 || f_out == 16'hFFFF);
    // R6
    no_flags_chk: assert (!(sel[2] || sel == 3'd0) || (!cout && !ovf));
    // R1
    add_sum_chk: assert (sel != 3'd3 || {cout, f_out} == ref_sum);
    // R2
    asb_sum_chk: assert (sel != 3'd2 || {cout, f_out} == ref_sum);
    // R3
    bsa_sum_chk: assert (sel != 3'd1 || {cout, f_out} == ref_sum);
    // R7
    overflow_chk: assert (sel[2] || sel == 3'd0 ||
                          ovf == ((ea[15] == eb[15]) && (f_out[15] != ea[15])));
  end
endmodule

bind alu16_la alu16_la_chk u_chk (
  .a_in(a_in), .b_in(b_in), .sel(sel), .cin(cin),
  .f_out(f_out), .cout(cout), .ovf(ovf)
);

// File: tb/alu16_la_bench.sv
module alu16_la_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] a, b;
  logic [2:0]  s;
  logic        c;
  logic [15:0] f;
  logic        co, ov;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu16_la u_alu16_la (
    .a_in(a), .b_in(b), .sel(s), .cin(c),
    .f_out(f), .cout(co), .ovf(ov)
  );

  task automatic model(input logic [15:0] ta, input logic [15:0] tb_,
                       input logic [2:0] ts, input logic tc,
                       output logic [15:0] ef, output logic ec, output logic eo);
    int unsigned xa, yb, tot;
    ec = 1'b0; eo = 1'b0;
    case (ts)
      3'd0: ef = 16'h0000;
      3'd4: ef = ta ^ tb_;
      3'd5: ef = ta | tb_;
      3'd6: ef = ta & tb_;
      3'd7: ef = 16'hFFFF;
      default: begin
        xa = (ts == 3'd1) ? (32'hFFFF - ta) : ta;
        yb = (ts == 3'd2) ? (32'hFFFF - tb_) : tb_;
        tot = xa + yb + tc;
        ef = tot[15:0];
        ec = tot[16];
        eo = (xa[15] == yb[15]) && (tot[15] != xa[15]);
      end
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] ts);
    case (ts)
      3'd1: return "R3";
      3'd2: return "R2";
      3'd3: return "R1";
      3'd4, 3'd5, 3'd6: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (a=%h b=%h sel=%0d cin=%0b)",
               tag, what, act, exp, a, b, s, c);
    end
  endtask

  task automatic apply(input logic [15:0] ta, input logic [15:0] tb_,
                       input logic [2:0] ts, input logic tc, input string force_tag);
    logic [15:0] ef;
    logic ec, eo;
    string tg, ftag;
    @(posedge clk);
    a = ta; b = tb_; s = ts; c = tc;
    model(ta, tb_, ts, tc, ef, ec, eo);
    tg = (force_tag == "") ? tag_of(ts) : force_tag;
    ftag = (ts[2] || ts == 3'd0) ? "R6" : tg;
    @(negedge clk);
    check(tg, "f_out", {16'd0, f}, {16'd0, ef});
    check(ftag, "cout", {31'd0, co}, {31'd0, ec});
    check((ts[2] || ts == 3'd0) ? "R6" : "R7", "ovf", {31'd0, ov}, {31'd0, eo});
  endtask

  initial begin
    logic [15:0] bv [4];
    bv[0] = 16'h0000; bv[1] = 16'h7FFF; bv[2] = 16'h8000; bv[3] = 16'hFFFF;
    a = '0; b = '0; s = '0; c = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R5", "reset f_out", {16'd0, f}, 32'd0);
    check("R6", "reset cout", {31'd0, co}, 32'd0);

    // R8 slice boundary carries
    apply(16'h000F, 16'h0001, 3'd3, 1'b0, "R8");
    apply(16'h00FF, 16'h0001, 3'd3, 1'b0, "R8");
    apply(16'h0FFF, 16'h0001, 3'd3, 1'b0, "R8");
    apply(16'hFFFF, 16'h0000, 3'd3, 1'b1, "R8");
    apply(16'h1000, 16'h0001, 3'd2, 1'b1, "R8");
    apply(16'h0001, 16'h1000, 3'd1, 1'b1, "R8");

    for (int ts = 0; ts < 8; ts++) begin
      for (int tc = 0; tc < 2; tc++) begin
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            apply(bv[i], bv[j], 3'(ts), 1'(tc), "");
        for (int k = 0; k < 40; k++)
          apply(16'($urandom), 16'($urandom), 3'(ts), 1'(tc), "");
      end
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule